// File: doc/BRIEF.md
# Address Generation Unit with Auto-Increment

This unit forms effective memory addresses for a load/store pipeline, apart from the main ALU. A request carries a 3-bit mode, a base register value, an index register value, an immediate field from the instruction, an extension word, and a 2-bit operand size. Direct modes add the base to the immediate, the index or the extension word. Indirect mode first reads a pointer from memory at the base address. Auto-modify modes step the base register up or down by the operand size and hand the stepped value back for writeback to the register file.

Direct and auto-modify requests produce a one-cycle `addrValid` pulse in the cycle after the request. An indirect request raises `fetchReq`, with `fetchAddr` holding the base value, until `fetchValid` arrives. The returned data then becomes the effective address one cycle later. While a fetch is outstanding the unit ignores new requests. All arithmetic wraps modulo 2^16.

Top module: `addr_gen_unit`

## Requirements
- R1: During and after reset, before any request, `addrValid`, `wbEn` and `fetchReq` are low.
- R2: Mode 0 (register plus immediate): one cycle after a sampled request, `addrValid` is high and `effAddr` = `baseVal` + `immField`.
- R3: Mode 1 (base plus index): one cycle after the request, `addrValid` is high and `effAddr` = `baseVal` + `indexVal`.
- R4: Mode 2 (register plus extension word): one cycle after the request, `addrValid` is high and `effAddr` = `baseVal` + `extWord`.
- R5: Mode 3 (indirect): one cycle after the request, `fetchReq` goes high with `fetchAddr` = the request's `baseVal`. Both are held until `fetchValid` is sampled high. In the next cycle `fetchReq` is low, `addrValid` is high for one cycle, and `effAddr` equals the sampled `fetchData`.
- R6: While `fetchReq` is high, `reqValid` is ignored: no `addrValid` or `wbEn` results from it. When no fetch is pending, `fetchValid` is ignored.
- R7: Modes 4 (pre-increment) and 5 (pre-decrement): one cycle after the request, `effAddr` and `wbValue` both equal `baseVal` plus or minus the step, and `wbEn` is high.
- R8: Modes 6 (post-increment) and 7 (post-decrement): one cycle after the request, `effAddr` = `baseVal`, `wbValue` = `baseVal` plus or minus the step, and `wbEn` is high.
- R9: The step is 1 for `opSize` 0, 2 for `opSize` 1, and 4 for `opSize` 2 or 3.
- R10: All sums and steps wrap modulo 2^16. No flag is raised.
- R11: `addrValid` and `wbEn` are pulses tied to a single request. `wbEn` is high only together with `addrValid` and only for modes 4 to 7. Requests in consecutive cycles each get their own result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Address request strobe |
| mode | input | 3 | Addressing mode code |
| baseVal | input | 16 | Base register value |
| indexVal | input | 16 | Index register value |
| immField | input | 16 | Immediate address field |
| extWord | input | 16 | Extension-word displacement |
| opSize | input | 2 | Operand size selecting the step |
| fetchData | input | 16 | Pointer read back from memory |
| fetchValid | input | 1 | `fetchData` is valid |
| fetchReq | output | 1 | Pointer fetch request |
| fetchAddr | output | 16 | Address of the pointer fetch |
| effAddr | output | 16 | Effective address |
| addrValid | output | 1 | `effAddr` is valid this cycle |
| wbValue | output | 16 | Updated base register value |
| wbEn | output | 1 | Write `wbValue` back to the base register |

## Verification
The only hidden state is the wait-for-pointer flag and the latched pointer address. A corrupted flag shows at the ports at once: `fetchReq` is either stuck high or dropped, and `addrValid` is lost or extra on the next cycle. A wrong latched base shows on `fetchAddr` during the wait. Errors in the arithmetic or in step selection show on `effAddr` or `wbValue` one cycle after the request. A reference model checked on every clock therefore flags any of these faults within one or two cycles of the stimulus that triggers them.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [2:0] {
    MODE_REG_IMM  = 3'd0,
    MODE_BASE_IDX = 3'd1,
    MODE_REG_EXT  = 3'd2,
    MODE_INDIRECT = 3'd3,
    MODE_PRE_INC  = 3'd4,
    MODE_PRE_DEC  = 3'd5,
    MODE_POST_INC = 3'd6,
    MODE_POST_DEC = 3'd7
  } aguMode_e;

  typedef struct packed {
    logic capDirect;  // latch a computed address this edge
    logic capFetch;   // latch the pointer address, start waiting
    logic capPtr;     // latch the returned pointer as the address
  } aguStrobe_t;
endpackage

// File: rtl/agu_ctrl.sv
module agu_ctrl
  import agu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [2:0] mode,
  input  logic       fetchValid,
  output aguStrobe_t strobe,
  output logic       fetchReq,
  output logic       addrValid,
  output logic       wbEn
);
  typedef enum logic {ST_IDLE, ST_WAIT} ctrlState_e;
  ctrlState_e state;
  aguMode_e   modeSel;
  logic       isModify;

  always_comb begin
    modeSel          = aguMode_e'(mode);
    isModify         = mode[2];
    strobe.capDirect = (state == ST_IDLE) && reqValid && (modeSel != MODE_INDIRECT);
    strobe.capFetch  = (state == ST_IDLE) && reqValid && (modeSel == MODE_INDIRECT);
    strobe.capPtr    = (state == ST_WAIT) && fetchValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      addrValid <= 1'b0;
      wbEn      <= 1'b0;
    end else begin
      addrValid <= strobe.capDirect || strobe.capPtr;
      wbEn      <= strobe.capDirect && isModify;
      if (strobe.capFetch)    state <= ST_WAIT;
      else if (strobe.capPtr) state <= ST_IDLE;
    end
  end

  assign fetchReq = (state == ST_WAIT);
endmodule

// File: rtl/agu_datapath.sv
module agu_datapath
  import agu_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  aguStrobe_t        strobe,
  input  logic [2:0]        mode,
  input  logic [ADDR_W-1:0] baseVal,
  input  logic [ADDR_W-1:0] indexVal,
  input  logic [ADDR_W-1:0] immField,
  input  logic [ADDR_W-1:0] extWord,
  input  logic [1:0]        opSize,
  input  logic [ADDR_W-1:0] fetchData,
  output logic [ADDR_W-1:0] fetchAddr,
  output logic [ADDR_W-1:0] effAddr,
  output logic [ADDR_W-1:0] wbValue
);
  localparam logic [ADDR_W-1:0] STEP_BYTE = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] STEP_HALF = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] STEP_WORD = ADDR_W'(4);

  logic [ADDR_W-1:0] stepVal, modifiedVal, directAddr;
  aguMode_e          modeSel;

  always_comb begin
    modeSel = aguMode_e'(mode);
    unique case (opSize)
      2'd0:    stepVal = STEP_BYTE;
      2'd1:    stepVal = STEP_HALF;
      default: stepVal = STEP_WORD;
    endcase
    modifiedVal = mode[0] ? (baseVal - stepVal) : (baseVal + stepVal);
    unique case (modeSel)
      MODE_REG_IMM:                directAddr = baseVal + immField;
      MODE_BASE_IDX:               directAddr = baseVal + indexVal;
      MODE_REG_EXT:                directAddr = baseVal + extWord;
      MODE_PRE_INC, MODE_PRE_DEC:  directAddr = modifiedVal;
      default:                     directAddr = baseVal;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fetchAddr <= '0;
      effAddr   <= '0;
      wbValue   <= '0;
    end else begin
      if (strobe.capFetch) fetchAddr <= baseVal;
      if (strobe.capDirect) begin
        effAddr <= directAddr;
        wbValue <= modifiedVal;
      end else if (strobe.capPtr) begin
        effAddr <= fetchData;
      end
    end
  end
endmodule

// File: rtl/addr_gen_unit.sv
module addr_gen_unit
  import agu_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [2:0]        mode,
  input  logic [ADDR_W-1:0] baseVal,
  input  logic [ADDR_W-1:0] indexVal,
  input  logic [ADDR_W-1:0] immField,
  input  logic [ADDR_W-1:0] extWord,
  input  logic [1:0]        opSize,
  input  logic [ADDR_W-1:0] fetchData,
  input  logic              fetchValid,
  output logic              fetchReq,
  output logic [ADDR_W-1:0] fetchAddr,
  output logic [ADDR_W-1:0] effAddr,
  output logic              addrValid,
  output logic [ADDR_W-1:0] wbValue,
  output logic              wbEn
);
  aguStrobe_t strobe;

  agu_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .mode(mode),
    .fetchValid(fetchValid), .strobe(strobe), .fetchReq(fetchReq),
    .addrValid(addrValid), .wbEn(wbEn)
  );

  agu_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .mode(mode),
    .baseVal(baseVal), .indexVal(indexVal), .immField(immField),
    .extWord(extWord), .opSize(opSize), .fetchData(fetchData),
    .fetchAddr(fetchAddr), .effAddr(effAddr), .wbValue(wbValue)
  );
endmodule

// File: rtl/agu_checker.sv
module agu_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [2:0]        mode,
  input logic [ADDR_W-1:0] baseVal,
  input logic              fetchValid,
  input logic              fetchReq,
  input logic [ADDR_W-1:0] fetchAddr,
  input logic [ADDR_W-1:0] effAddr,
  input logic              addrValid,
  input logic              wbEn
);
  // R5: fetch request held with a stable address until data returns
  a_r5_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    fetchReq && !fetchValid |=> fetchReq && $stable(fetchAddr));
  // R5: returned pointer completes the access next cycle
  a_r5_ptr_done: assert property (@(posedge clk) disable iff (!rstN)
    fetchReq && fetchValid |=> addrValid && !fetchReq && !wbEn);
  // R5: indirect request starts a fetch at the base value
  a_r5_fetch_start: assert property (@(posedge clk) disable iff (!rstN)
    !fetchReq && reqValid && mode == 3'd3 |=> fetchReq && fetchAddr == $past(baseVal));
  // R6: no result is produced while a fetch is pending
  a_r6_quiet_wait: assert property (@(posedge clk) disable iff (!rstN)
    fetchReq |-> !addrValid && !wbEn);
  // R8: post modes address the unmodified base
  a_r8_post_addr: assert property (@(posedge clk) disable iff (!rstN)
    !fetchReq && reqValid && mode[2:1] == 2'b11 |=> addrValid && wbEn && effAddr == $past(baseVal));
  // R11: writeback only alongside a valid address
  a_r11_wb_with_valid: assert property (@(posedge clk) disable iff (!rstN)
    wbEn |-> addrValid);
  // R11: no result without a request or returned pointer
  a_r11_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid && !fetchReq |=> !addrValid);
endmodule

bind addr_gen_unit agu_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .mode(mode), .baseVal(baseVal),
  .fetchValid(fetchValid), .fetchReq(fetchReq), .fetchAddr(fetchAddr),
  .effAddr(effAddr), .addrValid(addrValid), .wbEn(wbEn)
);

// File: tb/addr_gen_unit_test.sv
`timescale 1ns/1ps
module addr_gen_unit_test;
  logic        clk = 0, rstN = 0;
  logic        reqValid = 0, fetchValid = 0;
  logic [2:0]  mode = 0;
  logic [15:0] baseVal = 0, indexVal = 0, immField = 0, extWord = 0, fetchData = 0;
  logic [1:0]  opSize = 0;
  logic        fetchReq, addrValid, wbEn;
  logic [15:0] fetchAddr, effAddr, wbValue;

  addr_gen_unit uut (.*);

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  string curTag = "R1";
  bit done = 0;

  // reference model state
  bit waiting = 0, expValid = 0, expWb = 0;
  int expEff = 0, expWbVal = 0, expFAddr = 0;

  function automatic int stepOf(input logic [1:0] s);
    return (s == 0) ? 1 : (s == 1) ? 2 : 4;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waiting = 0; expValid = 0; expWb = 0;
    end else begin
      expValid = 0; expWb = 0;
      if (waiting) begin
        if (fetchValid) begin
          expValid = 1; expEff = fetchData; waiting = 0;
        end
      end else if (reqValid) begin
        int b, st;
        b = baseVal; st = stepOf(opSize);
        case (mode)
          0: begin expValid = 1; expEff = (b + immField) % 65536; end
          1: begin expValid = 1; expEff = (b + indexVal) % 65536; end
          2: begin expValid = 1; expEff = (b + extWord) % 65536; end
          3: begin waiting = 1; expFAddr = b; end
          4: begin expValid = 1; expWb = 1; expWbVal = (b + st) % 65536; expEff = expWbVal; end
          5: begin expValid = 1; expWb = 1; expWbVal = (b - st + 65536) % 65536; expEff = expWbVal; end
          6: begin expValid = 1; expWb = 1; expWbVal = (b + st) % 65536; expEff = b; end
          default: begin expValid = 1; expWb = 1; expWbVal = (b - st + 65536) % 65536; expEff = b; end
        endcase
      end
    end
  end

  task automatic check(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", curTag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (!done) begin
      check("addrValid", addrValid, expValid);
      check("wbEn", wbEn, expWb);
      check("fetchReq", fetchReq, waiting);
      if (expValid) check("effAddr", effAddr, expEff);
      if (expWb) check("wbValue", wbValue, expWbVal);
      if (waiting) check("fetchAddr", fetchAddr, expFAddr);
    end
  end

  task automatic req(input logic [2:0] m, input logic [15:0] b, input logic [15:0] other,
                     input logic [1:0] sz);
    @(negedge clk);
    reqValid = 1; mode = m; baseVal = b; opSize = sz;
    immField = other; indexVal = other; extWord = other;
    @(negedge clk);
    reqValid = 0; baseVal = 16'hDEAD; immField = 0; indexVal = 0; extWord = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1; checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    curTag = "R1";
    repeat (3) @(negedge clk);
    rstN = 1;
    idle(2);
    curTag = "R2"; req(0, 16'h1000, 16'h0234, 0); req(0, 16'h0004, 16'h0008, 0);
    curTag = "R10"; req(0, 16'hFFF0, 16'h0020, 0);
    curTag = "R3"; req(1, 16'h2000, 16'h0100, 0); req(1, 16'h8000, 16'h8001, 0);
    curTag = "R4"; req(2, 16'h3000, 16'h0FFF, 0); req(2, 16'h0001, 16'hFFFF, 0);
    curTag = "R5";
    req(3, 16'h4000, 0, 0);
    idle(2);
    fetchData = 16'hBEEF; fetchValid = 1; @(negedge clk); fetchValid = 0;
    idle(1);
    req(3, 16'h5000, 0, 0);
    fetchData = 16'h1234; fetchValid = 1; @(negedge clk); fetchValid = 0;
    idle(1);
    curTag = "R6";
    req(3, 16'h6000, 0, 0);
    req(0, 16'h1111, 16'h1111, 0);
    req(6, 16'h2222, 0, 1);
    fetchData = 16'hCAFE; fetchValid = 1; @(negedge clk); fetchValid = 0;
    idle(1);
    fetchData = 16'h9999; fetchValid = 1; @(negedge clk); fetchValid = 0;
    idle(2);
    curTag = "R7"; req(4, 16'h1000, 0, 0); req(5, 16'h1000, 0, 1);
    curTag = "R8"; req(6, 16'h2000, 0, 2); req(7, 16'h2000, 0, 0);
    curTag = "R9";
    for (int s = 0; s < 4; s++) begin
      req(4, 16'h0100, 0, 2'(s)); req(7, 16'h0100, 0, 2'(s));
    end
    curTag = "R10"; req(5, 16'h0000, 0, 0); req(6, 16'hFFFE, 0, 2); req(4, 16'hFFFF, 0, 0);
    curTag = "R11";
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      reqValid = ($urandom % 3) != 0;
      mode = 3'($urandom); baseVal = 16'($urandom);
      immField = 16'($urandom); indexVal = 16'($urandom); extWord = 16'($urandom);
      opSize = 2'($urandom);
      fetchValid = ($urandom % 2) == 0; fetchData = 16'($urandom);
    end
    @(negedge clk); reqValid = 0; fetchValid = 1;
    @(negedge clk); fetchValid = 0;
    idle(3);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule